// File: doc/BRIEF.md
# Peripheral DMA Channel

This block is a single DMA channel that copies data between memory and a peripheral FIFO. Software sets it up through a seven-word register window: the two starting addresses, a count, a request tag, a status word, a command word and a spare link address. Once the channel is armed and the controller-level enable is on, a pulse on the peripheral request line starts the work. The channel then moves units of 1, 2, 4, 16 or 32 bytes over a memory master port. Each unit is split into beats of up to four bytes, and every beat is a read followed by a write.

The count register is expressed in units rather than bytes, and it counts down live. Software can read it mid-transfer and multiply by the unit size to find the bytes still outstanding. The channel sets its done flag when the count reaches zero. It stops with an address-error flag, issuing no access, when a starting address is not a multiple of the width selected for that side.

The memory port is a valid/ready request channel. Once raised, a request keeps valid, write flag, address, size and write data steady until the cycle in which ready is high, and the handshake completes in that cycle. Read data comes back on a separate response strobe with no back-pressure. The channel keeps at most one read outstanding and waits for its data before it issues the matching write. Data on both paths is right-justified: the first byte at the address sits in bits [7:0].

Top module: `dma_chan_top`

## Requirements
- R1: After reset every register reads zero, the interrupt output is low and no memory request is valid.
- R2: Register word index (byte offset / 4) selects: 0 source address, 1 destination address, 2 count, 3 request tag (8 bits), 4 status, 5 command, 6 link address. Writes are read back, with undefined bits reading zero.
- R3: Command bits: 23 source increment, 22 destination increment, [15:14] source width, [13:12] destination width, [10:8] unit size, 7 block mode, 1 interrupt enable. Width codes: 0=4 bytes, 1=1 byte, 2=2 bytes, 3 treated as 4. Unit codes: 0=4, 1=1, 2=2, 3=16, 4=32 bytes, 5 to 7 treated as 4. Status bits: 0 enable, 1 count-terminate, 2 halt, 3 done, 4 address error, 6 link invalid, 31 no-link mode.
- R4: A unit begins only while status enable is set, `ctl_en` is high, `ctl_halt` is low and the status halt, done and address-error bits are clear. A request seen while gated stays pending.
- R5: Beat size is the unit size capped at 4 bytes. A unit is moved as a read then a write per beat, with `mem_size` 0=1, 1=2, 2=4 bytes. The written data equals the data read.
- R6: Within a unit and across units, a side with its increment flag set advances by the beat and unit size. A side without the flag stays on its starting address. After N units an incrementing register holds start + N × unit bytes.
- R7: The count register drops by one after each completed unit and reads back the units still outstanding.
- R8: In single mode each request pulse moves exactly one unit. In block mode one pulse moves the whole count.
- R9: When the last unit completes, the channel sets done (bit 3) and count-terminate (bit 1). `irq` equals done AND interrupt enable, and stays high until software writes the done bit clear.
- R10: If, at the start of a unit, the source is not a multiple of its width or the destination is not a multiple of its width, the channel sets address error (bit 4) and halt (bit 2) and issues no request.
- R11: If the count is zero while the channel is allowed to run, done and count-terminate are set with no memory request.
- R12: A memory request held without ready keeps valid, address and write flag unchanged until accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_en | input | 1 | Controller-level enable |
| ctl_halt | input | 1 | Controller-level halt |
| periph_req | input | 1 | Peripheral request pulse |
| reg_wr | input | 1 | Register write strobe |
| reg_idx | input | 3 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on reg_idx) |
| mem_valid | output | 1 | Memory request valid |
| mem_ready | input | 1 | Memory request accepted |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Byte address |
| mem_size | output | 2 | Beat size code |
| mem_wdata | output | 32 | Write data, right-justified |
| mem_rvalid | input | 1 | Read data strobe |
| mem_rdata | input | 32 | Read data, right-justified |
| irq | output | 1 | Transfer-complete interrupt |

## Verification
The bench goes after these cases:
- Units of 16 and 32 bytes, which split into several beats. Wrong beat stepping there would duplicate or skip words in the copied buffer.
- Fixed-address sides. A design that stepped a fixed side anyway would scatter FIFO data and leave the final address registers wrong.
- Single mode. A channel that ran ahead of the request pulses would show too many accesses and too low a count partway through.
- A zero count and a misaligned start address. Both must finish with no bus access; a faulty design would touch memory or hang with neither flag set.
- Random back-pressure. This catches a request that changes or drops before it is accepted, which would corrupt the copied data.

// File: rtl/dma_ch_pkg.sv
package dma_ch_pkg;

  typedef struct packed {
    logic       sinc;
    logic       dinc;
    logic [1:0] sw;
    logic [1:0] dw;
    logic [2:0] usz;
    logic       blk;
    logic       ie;
  } chan_cfg_t;

  typedef struct packed {
    logic nolink;
    logic linv;
    logic aerr;
    logic done;
    logic halt;
    logic cterm;
    logic en;
  } chan_stat_t;

  localparam logic [2:0] IDX_SRC  = 3'd0;
  localparam logic [2:0] IDX_DST  = 3'd1;
  localparam logic [2:0] IDX_CNT  = 3'd2;
  localparam logic [2:0] IDX_TAG  = 3'd3;
  localparam logic [2:0] IDX_STAT = 3'd4;
  localparam logic [2:0] IDX_CMD  = 3'd5;
  localparam logic [2:0] IDX_LINK = 3'd6;

  function automatic logic [5:0] unit_bytes(input logic [2:0] code);
    case (code)
      3'd1:    return 6'd1;
      3'd2:    return 6'd2;
      3'd3:    return 6'd16;
      3'd4:    return 6'd32;
      default: return 6'd4;
    endcase
  endfunction

  function automatic logic [2:0] width_bytes(input logic [1:0] code);
    case (code)
      2'd1:    return 3'd1;
      2'd2:    return 3'd2;
      default: return 3'd4;
    endcase
  endfunction

  function automatic logic [2:0] beat_bytes(input logic [2:0] code);
    logic [5:0] u;
    u = unit_bytes(code);
    return (u > 6'd4) ? 3'd4 : u[2:0];
  endfunction

  function automatic logic [1:0] size_code(input logic [2:0] b);
    case (b)
      3'd1:    return 2'd0;
      3'd2:    return 2'd1;
      default: return 2'd2;
    endcase
  endfunction

endpackage

// File: rtl/dma_ch_side.sv
module dma_ch_side
  import dma_ch_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic [AW-1:0] base,
  input  logic          inc,
  input  logic [1:0]    wcode,
  input  logic [5:0]    off,
  output logic [AW-1:0] addr,
  output logic          misal
);
  logic [2:0] wb;
  logic [1:0] mask;

  always_comb begin
    wb    = width_bytes(wcode);
    mask  = wb[1:0] - 2'd1;
    if (wb == 3'd4) mask = 2'd3;
    misal = (base[1:0] & mask) != 2'd0;
    addr  = base + (inc ? AW'(off) : '0);
  end
endmodule

// File: rtl/dma_ch_csr.sv
module dma_ch_csr
  import dma_ch_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [2:0]    reg_idx,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  input  logic          ctl_en,
  input  logic          ctl_halt,
  input  logic          unit_done,
  input  logic          zero_done,
  input  logic          aerr_evt,
  output logic [AW-1:0] src_q,
  output logic [AW-1:0] dst_q,
  output logic [CW-1:0] cnt_q,
  output chan_cfg_t     cfg_q,
  output logic          run,
  output logic          aerr_flag,
  output logic          irq
);
  logic [AW-1:0] link_q;
  logic [7:0]    tag_q;
  chan_stat_t    st_q;
  logic          fin;
  logic [5:0]    ub;
  logic          wr_cnt;

  assign ub        = unit_bytes(cfg_q.usz);
  assign fin       = zero_done | (unit_done & (cnt_q == CW'(1)));
  assign run       = st_q.en & ctl_en & ~ctl_halt & ~st_q.halt & ~st_q.done & ~st_q.aerr;
  assign irq       = st_q.done & cfg_q.ie;
  assign aerr_flag = st_q.aerr;
  assign wr_cnt    = reg_wr && reg_idx == IDX_CNT;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src_q  <= '0;
      dst_q  <= '0;
      cnt_q  <= '0;
      link_q <= '0;
      tag_q  <= '0;
      cfg_q  <= '0;
      st_q   <= '0;
    end else begin
      if (unit_done) begin
        src_q <= src_q + (cfg_q.sinc ? AW'(ub) : '0);
        dst_q <= dst_q + (cfg_q.dinc ? AW'(ub) : '0);
        cnt_q <= cnt_q - CW'(1);
      end
      if (reg_wr) begin
        case (reg_idx)
          IDX_SRC:  src_q  <= reg_wdata[AW-1:0];
          IDX_DST:  dst_q  <= reg_wdata[AW-1:0];
          IDX_CNT:  cnt_q  <= reg_wdata[CW-1:0];
          IDX_TAG:  tag_q  <= reg_wdata[7:0];
          IDX_LINK: link_q <= reg_wdata[AW-1:0];
          IDX_CMD:  cfg_q  <= '{sinc: reg_wdata[23], dinc: reg_wdata[22],
                                sw: reg_wdata[15:14], dw: reg_wdata[13:12],
                                usz: reg_wdata[10:8], blk: reg_wdata[7],
                                ie: reg_wdata[1]};
          IDX_STAT: st_q   <= '{nolink: reg_wdata[31], linv: reg_wdata[6],
                                aerr: reg_wdata[4], done: reg_wdata[3],
                                halt: reg_wdata[2], cterm: reg_wdata[1],
                                en: reg_wdata[0]};
          default: ;
        endcase
      end
      if (fin) begin
        st_q.done  <= 1'b1;
        st_q.cterm <= 1'b1;
      end
      if (aerr_evt) begin
        st_q.aerr <= 1'b1;
        st_q.halt <= 1'b1;
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_idx)
      IDX_SRC:  reg_rdata[AW-1:0] = src_q;
      IDX_DST:  reg_rdata[AW-1:0] = dst_q;
      IDX_CNT:  reg_rdata[CW-1:0] = cnt_q;
      IDX_TAG:  reg_rdata[7:0]    = tag_q;
      IDX_LINK: reg_rdata[AW-1:0] = link_q;
      IDX_CMD: begin
        reg_rdata[23]    = cfg_q.sinc;
        reg_rdata[22]    = cfg_q.dinc;
        reg_rdata[15:14] = cfg_q.sw;
        reg_rdata[13:12] = cfg_q.dw;
        reg_rdata[10:8]  = cfg_q.usz;
        reg_rdata[7]     = cfg_q.blk;
        reg_rdata[1]     = cfg_q.ie;
      end
      IDX_STAT: begin
        reg_rdata[31] = st_q.nolink;
        reg_rdata[6]  = st_q.linv;
        reg_rdata[4]  = st_q.aerr;
        reg_rdata[3]  = st_q.done;
        reg_rdata[2]  = st_q.halt;
        reg_rdata[1]  = st_q.cterm;
        reg_rdata[0]  = st_q.en;
      end
      default: reg_rdata = '0;
    endcase
  end

  AST_DONE_SW_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(st_q.done) |-> $past(reg_wr && reg_idx == IDX_STAT)); // R9

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (unit_done && !wr_cnt) |=> cnt_q == $past(cnt_q) - CW'(1)); // R7

endmodule

// File: rtl/dma_ch_seq.sv
module dma_ch_seq
  import dma_ch_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 16,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          periph_req,
  input  logic [AW-1:0] src,
  input  logic [AW-1:0] dst,
  input  logic [CW-1:0] cnt,
  input  logic          sinc,
  input  logic          dinc,
  input  logic [1:0]    sw,
  input  logic [1:0]    dw,
  input  logic [2:0]    usz,
  input  logic          blk,
  output logic          unit_done,
  output logic          zero_done,
  output logic          aerr_evt,
  output logic          mem_valid,
  input  logic          mem_ready,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [1:0]    mem_size,
  output logic [DW-1:0] mem_wdata,
  input  logic          mem_rvalid,
  input  logic [DW-1:0] mem_rdata
);
  localparam int NSIDE = 2;

  typedef enum logic [1:0] {S_IDLE, S_RD, S_RWAIT, S_WR} seq_st_t;

  seq_st_t       st_q;
  logic [5:0]    off_q;
  logic [DW-1:0] buf_q;
  logic          pend_q;
  logic [2:0]    beat;
  logic [5:0]    ub;
  logic          last_beat;
  logic          start;
  logic          pend_clr;

  logic [AW-1:0] side_base [NSIDE];
  logic          side_inc  [NSIDE];
  logic [1:0]    side_w    [NSIDE];
  logic [AW-1:0] side_addr [NSIDE];
  logic          side_mis  [NSIDE];

  assign side_base[0] = src;
  assign side_base[1] = dst;
  assign side_inc[0]  = sinc;
  assign side_inc[1]  = dinc;
  assign side_w[0]    = sw;
  assign side_w[1]    = dw;

  for (genvar g = 0; g < NSIDE; g++) begin : g_side
    dma_ch_side #(.AW(AW)) u_side (
      .base  (side_base[g]),
      .inc   (side_inc[g]),
      .wcode (side_w[g]),
      .off   (off_q),
      .addr  (side_addr[g]),
      .misal (side_mis[g])
    );
  end

  assign beat      = beat_bytes(usz);
  assign ub        = unit_bytes(usz);
  assign last_beat = (off_q + {3'b000, beat}) == ub;

  always_comb begin
    zero_done = 1'b0;
    aerr_evt  = 1'b0;
    start     = 1'b0;
    if (st_q == S_IDLE && run) begin
      if (cnt == '0)                      zero_done = 1'b1;
      else if (pend_q && (side_mis[0] || side_mis[1])) aerr_evt = 1'b1;
      else if (pend_q)                    start     = 1'b1;
    end
    unit_done = (st_q == S_WR) && mem_ready && last_beat;
    pend_clr  = zero_done | aerr_evt | (start & ~blk) |
                (unit_done & (cnt == CW'(1)));
  end

  assign mem_valid = (st_q == S_RD) || (st_q == S_WR);
  assign mem_we    = (st_q == S_WR);
  assign mem_addr  = (st_q == S_WR) ? side_addr[1] : side_addr[0];
  assign mem_size  = size_code(beat);
  assign mem_wdata = buf_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      off_q  <= '0;
      buf_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      pend_q <= (pend_q & ~pend_clr) | periph_req;
      case (st_q)
        S_IDLE: if (start) st_q <= S_RD;
        S_RD:   if (mem_ready) st_q <= S_RWAIT;
        S_RWAIT: if (mem_rvalid) begin
          buf_q <= mem_rdata;
          st_q  <= S_WR;
        end
        S_WR: if (mem_ready) begin
          if (last_beat) begin
            off_q <= '0;
            st_q  <= S_IDLE;
          end else begin
            off_q <= off_q + {3'b000, beat};
            st_q  <= S_RD;
          end
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_we))); // R12

  AST_ZERO_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    zero_done |=> !mem_valid); // R11

  AST_START_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_RD && $past(st_q) == S_IDLE) |-> $past(run)); // R4

endmodule

// File: rtl/dma_chan_top.sv
module dma_chan_top
  import dma_ch_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 16,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ctl_en,
  input  logic          ctl_halt,
  input  logic          periph_req,
  input  logic          reg_wr,
  input  logic [2:0]    reg_idx,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  output logic          mem_valid,
  input  logic          mem_ready,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [1:0]    mem_size,
  output logic [DW-1:0] mem_wdata,
  input  logic          mem_rvalid,
  input  logic [DW-1:0] mem_rdata,
  output logic          irq
);
  logic [AW-1:0] src_q, dst_q;
  logic [CW-1:0] cnt_q;
  chan_cfg_t     cfg_q;
  logic          run, aerr_flag;
  logic          unit_done, zero_done, aerr_evt;

  dma_ch_csr #(.AW(AW), .CW(CW)) u_csr (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_idx   (reg_idx),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .ctl_en    (ctl_en),
    .ctl_halt  (ctl_halt),
    .unit_done (unit_done),
    .zero_done (zero_done),
    .aerr_evt  (aerr_evt),
    .src_q     (src_q),
    .dst_q     (dst_q),
    .cnt_q     (cnt_q),
    .cfg_q     (cfg_q),
    .run       (run),
    .aerr_flag (aerr_flag),
    .irq       (irq)
  );

  dma_ch_seq #(.AW(AW), .CW(CW), .DW(DW)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .run        (run),
    .periph_req (periph_req),
    .src        (src_q),
    .dst        (dst_q),
    .cnt        (cnt_q),
    .sinc       (cfg_q.sinc),
    .dinc       (cfg_q.dinc),
    .sw         (cfg_q.sw),
    .dw         (cfg_q.dw),
    .usz        (cfg_q.usz),
    .blk        (cfg_q.blk),
    .unit_done  (unit_done),
    .zero_done  (zero_done),
    .aerr_evt   (aerr_evt),
    .mem_valid  (mem_valid),
    .mem_ready  (mem_ready),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .mem_size   (mem_size),
    .mem_wdata  (mem_wdata),
    .mem_rvalid (mem_rvalid),
    .mem_rdata  (mem_rdata)
  );

  AST_AERR_NO_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    aerr_flag |-> !mem_valid); // R10

endmodule

// File: tb/dma_chan_top_tb_top.sv
`timescale 1ns/1ps
module dma_chan_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctl_en = 1'b1, ctl_halt = 1'b0, periph_req = 1'b0;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_idx = 3'd0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic        mem_valid, mem_ready, mem_we, mem_rvalid, irq;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic [1:0]  mem_size;

  int errors = 0, checks = 0, acc = 0;
  logic [7:0]  mem [0:4095];
  logic [7:0]  emem [0:4095];
  logic        rpend = 1'b0;
  logic [31:0] rdat_pend = '0;

  always #2 clk = ~clk;

  dma_chan_top dut_i (.*);

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // memory responder: ready and read data decided between edges
  initial begin
    mem_ready = 1'b0; mem_rvalid = 1'b0; mem_rdata = '0;
    forever begin
      @(negedge clk);
      mem_rvalid = rpend; mem_rdata = rdat_pend; rpend = 1'b0;
      mem_ready = rst_n && ($urandom % 4 != 0);
      if (mem_valid && mem_ready) begin
        acc++;
        if (mem_we) begin
          for (int b = 0; b < (1 << mem_size); b++)
            mem[(mem_addr[11:0] + b) & 12'hFFF] = mem_wdata[8*b +: 8];
        end else begin
          rdat_pend = '0;
          for (int b = 0; b < (1 << mem_size); b++)
            rdat_pend[8*b +: 8] = mem[(mem_addr[11:0] + b) & 12'hFFF];
          rpend = 1'b1;
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  task automatic wr(input logic [2:0] i, input logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_idx = i; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] i, output logic [31:0] d);
    reg_idx = i; #1; d = reg_rdata;
  endtask

  task automatic pulse();
    @(negedge clk); periph_req = 1'b1;
    @(negedge clk); periph_req = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_end(input int lim);
    logic [31:0] s;
    for (int k = 0; k < lim; k++) begin
      @(negedge clk); rd(3'd4, s);
      if (s[3] || s[4]) break;
    end
  endtask

  function automatic int ubytes(input int c);
    case (c) 1: return 1; 2: return 2; 3: return 16; 4: return 32; default: return 4; endcase
  endfunction

  function automatic logic [31:0] cmd_word(input bit si, input bit di, input int sw, input int dw,
                                          input int us, input bit bk, input bit ie);
    return (32'(si) << 23) | (32'(di) << 22) | (32'(sw) << 14) | (32'(dw) << 12) |
           (32'(us) << 8) | (32'(bk) << 7) | (32'(ie) << 1);
  endfunction

  function automatic void ref_copy(input int s0, input int d0, input int n, input int us,
                                   input bit si, input bit di);
    int u = ubytes(us);
    int b = (u > 4) ? 4 : u;
    for (int k = 0; k < n; k++)
      for (int j = 0; j < u; j += b)
        for (int q = 0; q < b; q++)
          emem[(d0 + (di ? k*u + j : 0) + q) & 4095] = emem[(s0 + (si ? k*u + j : 0) + q) & 4095];
  endfunction

  function automatic int mem_diff();
    for (int a = 0; a < 4096; a++) if (mem[a] !== emem[a]) return a;
    return -1;
  endfunction

  task automatic fill_mem();
    for (int a = 0; a < 4096; a++) begin
      mem[a] = (a < 2048) ? 8'($urandom) : 8'h00;
      emem[a] = mem[a];
    end
  endtask

  initial begin
    logic [31:0] v;
    void'($urandom(32'd20240611));
    fill_mem();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int i = 0; i < 7; i++) begin
      rd(3'(i), v);
      chk(v == 0, "R1 reset reg", v, 0);
    end
    chk(irq == 0 && mem_valid == 0, "R1 irq/valid", {irq, mem_valid}, 0);

    // R2 / R3 register window
    wr(3'd0, 32'h1234_5678); wr(3'd1, 32'h0000_0ABC); wr(3'd3, 32'h0000_01FF);
    wr(3'd6, 32'hA5A5_A5A4); wr(3'd5, 32'hFFFF_FFFF); wr(3'd4, 32'h8000_0054);
    rd(3'd0, v); chk(v == 32'h1234_5678, "R2 source", v, 32'h1234_5678);
    rd(3'd1, v); chk(v == 32'h0000_0ABC, "R2 destination", v, 32'hABC);
    rd(3'd3, v); chk(v == 32'h0000_00FF, "R2 tag", v, 32'hFF);
    rd(3'd6, v); chk(v == 32'hA5A5_A5A4, "R2 link", v, 32'hA5A5_A5A4);
    rd(3'd5, v); chk(v == 32'h00C0_F782, "R3 command", v, 32'h00C0_F782);
    rd(3'd4, v); chk(v == 32'h8000_0054, "R3 status", v, 32'h8000_0054);
    chk(mem_valid == 0, "R2 no access", mem_valid, 0);
    wr(3'd4, 0);

    // R4 gating by controller enable and halt
    acc = 0; ctl_en = 1'b0;
    wr(3'd0, 32'h0); wr(3'd1, 32'h800); wr(3'd2, 2);
    wr(3'd5, cmd_word(1, 1, 0, 0, 0, 1, 0)); wr(3'd4, 1);
    pulse(); idle(30);
    rd(3'd2, v); chk(acc == 0 && v == 2, "R4 ctl_en low", acc, 0);
    ctl_en = 1'b1; ctl_halt = 1'b1; idle(30);
    chk(acc == 0, "R4 ctl_halt high", acc, 0);
    ctl_halt = 1'b0; wait_end(400);
    rd(3'd4, v); chk(v[3] == 1'b1 && acc == 4, "R4 pending request runs", acc, 4);
    wr(3'd4, 0);

    // R8 single mode, R7 live count, R9 irq hold and clear
    fill_mem(); ref_copy(32'h40, 32'h840, 3, 0, 1, 1);
    acc = 0;
    wr(3'd0, 32'h40); wr(3'd1, 32'h840); wr(3'd2, 3);
    wr(3'd5, cmd_word(1, 1, 0, 0, 0, 0, 1)); wr(3'd4, 1);
    idle(20); chk(acc == 0, "R8 no request no access", acc, 0);
    pulse(); idle(40);
    rd(3'd2, v); chk(v == 2 && acc == 2, "R7 count after one unit", v, 2);
    chk(acc == 2, "R8 one unit per pulse", acc, 2);
    pulse(); idle(40); pulse(); wait_end(400);
    rd(3'd2, v); chk(v == 0, "R7 count zero", v, 0);
    rd(3'd4, v); chk(v == 32'h0000_000B, "R9 done status", v, 32'hB);
    idle(5); chk(irq == 1'b1, "R9 irq held", irq, 1);
    chk(mem_diff() < 0, "R8 single mode data", mem_diff(), 32'hFFFF_FFFF);
    wr(3'd4, 0); chk(irq == 1'b0, "R9 irq cleared", irq, 0);

    // R10 misaligned source
    acc = 0;
    wr(3'd0, 32'h102); wr(3'd1, 32'h900); wr(3'd2, 4);
    wr(3'd5, cmd_word(1, 1, 0, 0, 3, 1, 1)); wr(3'd4, 1);
    pulse(); idle(20);
    rd(3'd4, v); chk(v == 32'h0000_0015 && acc == 0, "R10 source misaligned", v, 32'h15);
    wr(3'd4, 0);
    // R10 misaligned destination, 16-bit width
    wr(3'd0, 32'h100); wr(3'd1, 32'h901);
    wr(3'd5, cmd_word(1, 1, 2, 2, 2, 1, 0)); wr(3'd4, 1);
    pulse(); idle(20);
    rd(3'd4, v); chk(v[4] == 1'b1 && acc == 0, "R10 destination misaligned", v, 32'h15);
    wr(3'd4, 0);

    // R11 zero count
    acc = 0; wr(3'd2, 0); wr(3'd0, 32'h100); wr(3'd1, 32'h900);
    wr(3'd5, cmd_word(1, 1, 0, 0, 0, 1, 1)); wr(3'd4, 1);
    idle(10);
    rd(3'd4, v); chk(v == 32'h0000_000B && acc == 0, "R11 zero count", v, 32'hB);
    chk(irq == 1'b1, "R11 irq", irq, 1);
    wr(3'd4, 0);

    // R5 R6 R7 R8 R12 random transfers under random back-pressure
    for (int it = 0; it < 24; it++) begin
      int us = $urandom % 5;
      int u = ubytes(us);
      int b = (u > 4) ? 4 : u;
      int sw = (b == 1) ? 1 : (b == 2) ? 1 + ($urandom % 2) : $urandom % 3;
      int dw = (b == 1) ? 1 : (b == 2) ? 1 + ($urandom % 2) : $urandom % 3;
      int n = 1 + $urandom % 8;
      int s0 = ($urandom % 16) * 32;
      int d0 = 2048 + ($urandom % 16) * 32;
      bit si = 1'($urandom), di = 1'($urandom), bk = 1'($urandom), ie = 1'($urandom);
      logic [31:0] e;
      fill_mem(); ref_copy(s0, d0, n, us, si, di);
      acc = 0;
      wr(3'd0, 32'(s0)); wr(3'd1, 32'(d0)); wr(3'd2, 32'(n));
      wr(3'd5, cmd_word(si, di, sw, dw, us, bk, ie)); wr(3'd4, 1);
      if (bk) begin
        pulse(); wait_end(3000);
      end else begin
        for (int k = 0; k < n; k++) begin pulse(); idle(60); end
        wait_end(500);
      end
      chk(mem_diff() < 0, "R5 copied data", mem_diff(), 32'hFFFF_FFFF);
      chk(acc == 2 * n * (u / b), "R5 beat count", acc, 2 * n * (u / b));
      e = si ? 32'(s0 + n * u) : 32'(s0);
      rd(3'd0, v); chk(v == e, "R6 source end", v, e);
      e = di ? 32'(d0 + n * u) : 32'(d0);
      rd(3'd1, v); chk(v == e, "R6 destination end", v, e);
      rd(3'd2, v); chk(v == 0, "R7 count drained", v, 0);
      rd(3'd4, v); chk(v == 32'h0000_000B, "R8 finished status", v, 32'hB);
      chk(irq == ie, "R9 irq vs enable", irq, 32'(ie));
      wr(3'd4, 0);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule